// File: doc/BRIEF.md
# Five-Step Multicycle Load/Store Processor Core

This block is a small 32-bit unpipelined processor. Every instruction is carried through the same five sequential steps: fetch, decode with register read, ALU operation, memory access, and register write-back. A step with nothing to do is still spent as an idle cycle, so every instruction costs exactly five clock cycles.

The core holds a byte-addressed program counter, an instruction register, a 32-entry register file, a four-function ALU, and memory address and memory data registers. The register file has two operand read ports and one write port. Code and data are held in two small internal word arrays. A preload port fills either array while the core is held in reset. Progress is observed through a halted flag and a combinational debug read port onto the register file.

The sequencer has six states. ST_FETCH always goes to ST_DECODE. ST_DECODE always goes to ST_EXEC. ST_EXEC always goes to ST_MEM. ST_MEM always goes to ST_WB. ST_WB goes to ST_HALT when the current instruction is halt, and to ST_FETCH otherwise. ST_HALT stays in ST_HALT until reset.

Top module: `fivestep_core`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `halted` is 0. Reset clears the PC to 0 and puts the sequencer in ST_FETCH, so execution starts at code word 0.
- R2: Every instruction, halt included, takes exactly five cycles. The PC advances by 4 in the fetch step. A program of N executed instructions ending in halt raises `halted` exactly 5*N cycles after reset is released.
- R3: The instruction fields are opcode [31:26], rd [25:21], rs [20:16] and rt [15:11]. The constant is [15:0], sign-extended to 32 bits.
- R4: The opcodes add=0, sub=1, and=2 and or=3 write rs op rt into rd. Subtraction wraps modulo 2^32.
- R5: ld (opcode 4) writes data word ((rs + constant) mod 64) into rd. A negative constant is allowed.
- R6: st (opcode 5) writes the register named by the rd field into data word ((rs + constant) mod 64).
- R7: ldi (opcode 6) writes the sign-extended constant into rd. addi (opcode 7) writes rs + constant into rd.
- R8: bne (opcode 8) compares the registers named by rd and rs. If they differ, the PC is set to the constant, used as an absolute byte address. If they are equal, execution falls through to PC+4.
- R9: halt (opcode 63) raises `halted` after its five steps. From then on `halted`, the PC and every register hold their values until reset.
- R10: Any other opcode is a no-op. It writes no register and no data word.
- R11: When `load_en` is high, `load_data` is written to word `load_addr` of the code array (`load_sel`=0) or of the data array (`load_sel`=1).
- R12: `dbg_data` shows register `dbg_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Preload write strobe |
| load_sel | input | 1 | Preload target: 0 code, 1 data |
| load_addr | input | 6 | Preload word address |
| load_data | input | 32 | Preload word |
| dbg_addr | input | 5 | Debug register select |
| dbg_data | output | 32 | Debug register value |
| halted | output | 1 | Core has executed halt |

## Verification
The ALU paths are swept with every ordered pair taken from eight load-immediate constants: zero, one, minus one, the largest and smallest 16-bit values, two mixed bit patterns and a small odd value. This exposes sign-extension faults, wrong function selection and swapped subtract operands, and each result is compared against arithmetic done in the bench. A count-by-three loop exercises a backward taken branch and its final fall-through. An array-sum program exercises offset loads (including a negative offset), a store read back through a load, an unknown opcode that must leave a register and a data word untouched, and the hold after halt. Every run's cycle count to `halted` is checked against five times the number of instructions executed, which catches any skipped or extra step.

// File: rtl/fivestep_pkg.sv
package fivestep_pkg;

    typedef enum logic [5:0] {
        OP_ADD  = 6'd0,
        OP_SUB  = 6'd1,
        OP_AND  = 6'd2,
        OP_OR   = 6'd3,
        OP_LD   = 6'd4,
        OP_ST   = 6'd5,
        OP_LDI  = 6'd6,
        OP_ADDI = 6'd7,
        OP_BNE  = 6'd8,
        OP_HALT = 6'd63
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEM,
        ST_WB,
        ST_HALT
    } step_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR
    } alu_fn_e;

endpackage

// File: rtl/fivestep_regfile.sv
module fivestep_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int RA_W = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [RA_W-1:0] waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [RA_W-1:0] raddr_x,
    input  logic [RA_W-1:0] raddr_y,
    input  logic [RA_W-1:0] raddr_d,
    output logic [XLEN-1:0] rdata_x,
    output logic [XLEN-1:0] rdata_y,
    output logic [XLEN-1:0] rdata_d
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_x = regs[raddr_x];
    assign rdata_y = regs[raddr_y];
    assign rdata_d = regs[raddr_d];
endmodule

// File: rtl/fivestep_alu.sv
module fivestep_alu
    import fivestep_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_fn_e         fn,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            zero
);
    always_comb begin
        unique case (fn)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/fivestep_seq.sv
module fivestep_seq
    import fivestep_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  halt_req,
    output step_e step,
    output logic  halted
);
    step_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step <= ST_FETCH;
        end else begin
            step <= nxt;
        end
    end

    always_comb begin
        unique case (step)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: nxt = ST_EXEC;
            ST_EXEC:   nxt = ST_MEM;
            ST_MEM:    nxt = ST_WB;
            ST_WB:     nxt = halt_req ? ST_HALT : ST_FETCH;
            ST_HALT:   nxt = ST_HALT;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_comb begin
        halted = (step == ST_HALT);
    end
endmodule

// File: rtl/fivestep_core.sv
module fivestep_core
    import fivestep_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NREG   = 32,
    parameter int MEM_AW = 6,
    localparam int RA_W      = $clog2(NREG),
    localparam int MEM_WORDS = 1 << MEM_AW,
    localparam int PC_W      = MEM_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              load_sel,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [XLEN-1:0]   load_data,
    input  logic [RA_W-1:0]   dbg_addr,
    output logic [XLEN-1:0]   dbg_data,
    output logic              halted
);
    logic [XLEN-1:0] code_mem [MEM_WORDS];
    logic [XLEN-1:0] data_mem [MEM_WORDS];

    logic [PC_W-1:0] pc;
    logic [XLEN-1:0] ir, a_q, b_q, alu_q, mdr;
    step_e           step;

    opcode_e         op;
    logic [RA_W-1:0] f_rd, f_rs, f_rt, y_addr;
    logic [XLEN-1:0] imm_sx, rd_x, rd_y, alu_a, alu_b, alu_y, wb_data;
    logic            alu_zero;
    alu_fn_e         alu_fn;
    logic            use_imm, zero_a, rd_write, from_mem;
    logic            is_ld, is_st, is_bne, is_halt;
    logic            rf_we, core_st_we;

    // field split
    assign op     = opcode_e'(ir[31:26]);
    assign f_rd   = ir[25:21];
    assign f_rs   = ir[20:16];
    assign f_rt   = ir[15:11];
    assign imm_sx = {{(XLEN-16){ir[15]}}, ir[15:0]};

    // decode
    always_comb begin
        alu_fn   = ALU_ADD;
        use_imm  = 1'b0;
        zero_a   = 1'b0;
        rd_write = 1'b0;
        from_mem = 1'b0;
        is_ld    = 1'b0;
        is_st    = 1'b0;
        is_bne   = 1'b0;
        is_halt  = 1'b0;
        unique case (op)
            OP_ADD:  rd_write = 1'b1;
            OP_SUB:  begin alu_fn = ALU_SUB; rd_write = 1'b1; end
            OP_AND:  begin alu_fn = ALU_AND; rd_write = 1'b1; end
            OP_OR:   begin alu_fn = ALU_OR;  rd_write = 1'b1; end
            OP_LD:   begin use_imm = 1'b1; is_ld = 1'b1; rd_write = 1'b1; from_mem = 1'b1; end
            OP_ST:   begin use_imm = 1'b1; is_st = 1'b1; end
            OP_LDI:  begin use_imm = 1'b1; zero_a = 1'b1; rd_write = 1'b1; end
            OP_ADDI: begin use_imm = 1'b1; rd_write = 1'b1; end
            OP_BNE:  begin alu_fn = ALU_SUB; is_bne = 1'b1; end
            OP_HALT: is_halt = 1'b1;
            default: ;
        endcase
    end

    // store data and branch compare come from the rd field
    assign y_addr = (is_st || is_bne) ? f_rd : f_rt;

    assign rf_we      = (step == ST_WB) && rd_write;
    assign core_st_we = (step == ST_MEM) && is_st;
    assign wb_data    = from_mem ? mdr : alu_q;
    assign alu_a      = zero_a ? '0 : a_q;
    assign alu_b      = use_imm ? imm_sx : b_q;

    fivestep_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_req (is_halt),
        .step     (step),
        .halted   (halted)
    );

    fivestep_regfile #(.XLEN(XLEN), .NREG(NREG)) rf_i (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (f_rd),
        .wdata   (wb_data),
        .raddr_x (f_rs),
        .raddr_y (y_addr),
        .raddr_d (dbg_addr),
        .rdata_x (rd_x),
        .rdata_y (rd_y),
        .rdata_d (dbg_data)
    );

    fivestep_alu #(.XLEN(XLEN)) alu_i (
        .fn   (alu_fn),
        .a    (alu_a),
        .b    (alu_b),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // datapath registers, one step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc    <= '0;
            ir    <= '0;
            a_q   <= '0;
            b_q   <= '0;
            alu_q <= '0;
            mdr   <= '0;
        end else begin
            unique case (step)
                ST_FETCH: begin
                    ir <= code_mem[pc[PC_W-1:2]];
                    pc <= pc + PC_W'(4);
                end
                ST_DECODE: begin
                    a_q <= rd_x;
                    b_q <= rd_y;
                end
                ST_EXEC: begin
                    alu_q <= alu_y;
                    mdr   <= b_q;
                    if (is_bne && !alu_zero) begin
                        pc <= imm_sx[PC_W-1:0];
                    end
                end
                ST_MEM: begin
                    if (is_ld) begin
                        mdr <= data_mem[alu_q[MEM_AW-1:0]];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (load_en && !load_sel) begin
            code_mem[load_addr] <= load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (load_en && load_sel) begin
            data_mem[load_addr] <= load_data;
        end else if (core_st_we) begin
            data_mem[alu_q[MEM_AW-1:0]] <= mdr;
        end
    end
endmodule

// File: rtl/fivestep_chk.sv
module fivestep_chk
    import fivestep_pkg::*;
#(
    parameter int PC_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input step_e           step,
    input logic [PC_W-1:0] pc,
    input logic            halted,
    input logic            rf_we,
    input logic            st_we
);
    // R2
    fetch_pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_FETCH) |=> (step == ST_DECODE) && (pc == PC_W'($past(pc) + PC_W'(4))));

    // R2
    decode_to_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_DECODE) |=> (step == ST_EXEC));

    // R2
    exec_to_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_EXEC) |=> (step == ST_MEM));

    // R2
    mem_to_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step == ST_MEM) |=> (step == ST_WB));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted && $stable(pc));

    // R9
    no_write_after_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !rf_we && !st_we);

    // R2
    reg_write_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (step == ST_WB));

    // R6
    store_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_we |-> (step == ST_MEM));
endmodule

bind fivestep_core fivestep_chk #(.PC_W(PC_W)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .pc     (pc),
    .halted (halted),
    .rf_we  (rf_we),
    .st_we  (core_st_we)
);

// File: tb/fivestep_core_tb_top.sv
module fivestep_core_tb_top;
    localparam logic [5:0] C_ADD = 6'd0, C_SUB = 6'd1, C_AND = 6'd2, C_OR = 6'd3;
    localparam logic [5:0] C_LD = 6'd4, C_ST = 6'd5, C_LDI = 6'd6, C_ADDI = 6'd7;
    localparam logic [5:0] C_BNE = 6'd8, C_HALT = 6'd63, C_UNK = 6'd20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic        load_sel = 1'b0;
    logic [5:0]  load_addr = '0;
    logic [31:0] load_data = '0;
    logic [4:0]  dbg_addr = '0;
    logic [31:0] dbg_data;
    logic        halted;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] prog [64];

    always #2 clk = ~clk;

    fivestep_core dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_sel(load_sel),
        .load_addr(load_addr), .load_data(load_data),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data), .halted(halted)
    );

    function automatic logic [31:0] enc_r(logic [5:0] op, int rd, int rs, int rt);
        return {op, 5'(rd), 5'(rs), 5'(rt), 11'd0};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rd, int rs, logic [15:0] c);
        return {op, 5'(rd), 5'(rs), c};
    endfunction

    function automatic logic [31:0] sx(logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic peek(input int idx, output logic [31:0] v);
        dbg_addr = 5'(idx);
        #1;
        v = dbg_data;
    endtask

    task automatic wr(input logic sel, input int addr, input logic [31:0] d);
        @(negedge clk);
        load_en = 1'b1; load_sel = sel; load_addr = 6'(addr); load_data = d;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run_prog(input int np, input int exp_cyc, input string tag);
        int cyc;
        for (int k = 0; k < np; k++) wr(1'b0, k, prog[k]);
        @(negedge clk);
        check({"R1 halted in reset ", tag}, 32'(halted), 32'd0);
        rst_n = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) check({"R1 halted after release ", tag}, 32'(halted), 32'd0);
        end while (!halted && cyc < 3000);
        if (cyc >= 3000) begin
            n_tests++; n_fail++;
            $display("FAIL R9 %s: actual no halt expected halt", tag);
        end
        check({"R2 cycles to halt ", tag}, 32'(cyc), 32'(exp_cyc));
    endtask

    task automatic end_run();
        @(negedge clk);
        rst_n = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] vals [8];
        logic [31:0] v, a, b, h0, h3;
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'hFFFF; vals[3] = 16'h7FFF;
        vals[4] = 16'h8000; vals[5] = 16'h1234; vals[6] = 16'h5A5A; vals[7] = 16'h0003;
        repeat (3) @(negedge clk);

        // R4 R7 R3: ALU sweep over all ordered operand pairs
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                a = sx(vals[i]);
                b = sx(vals[j]);
                prog[0] = enc_i(C_LDI, 1, 0, vals[i]);
                prog[1] = enc_i(C_LDI, 2, 0, vals[j]);
                prog[2] = enc_r(C_ADD, 3, 1, 2);
                prog[3] = enc_r(C_SUB, 4, 1, 2);
                prog[4] = enc_r(C_AND, 5, 1, 2);
                prog[5] = enc_r(C_OR,  6, 1, 2);
                prog[6] = enc_r(C_HALT, 0, 0, 0);
                run_prog(7, 35, $sformatf("alu %0d,%0d", i, j));
                peek(1, v); check($sformatf("R7 ldi sign-extend %0d", i), v, a);
                peek(3, v); check($sformatf("R4 add %0d,%0d", i, j), v, a + b);
                peek(4, v); check($sformatf("R4 sub %0d,%0d", i, j), v, a - b);
                peek(5, v); check($sformatf("R4 and %0d,%0d", i, j), v, a & b);
                peek(6, v); check($sformatf("R4 or %0d,%0d", i, j), v, a | b);
                end_run();
            end
        end

        // R8 R7: count-by-three loop, backward branch then fall-through
        prog[0] = enc_i(C_LDI, 0, 0, 16'd0);
        prog[1] = enc_i(C_LDI, 1, 0, 16'd4);
        prog[2] = enc_i(C_LDI, 2, 0, 16'd0);
        prog[3] = enc_i(C_ADDI, 2, 2, 16'd3);
        prog[4] = enc_i(C_ADDI, 0, 0, 16'd1);
        prog[5] = enc_i(C_BNE, 0, 1, 16'd12);
        prog[6] = enc_r(C_HALT, 0, 0, 0);
        run_prog(7, 5 * (3 + 4 * 3 + 1), "loop3");
        peek(2, v); check("R8 loop sum r2", v, 32'd12);
        peek(0, v); check("R8 loop counter r0", v, 32'd4);
        end_run();

        // R11 R5 R6 R10: array sum, store/load, unknown opcode
        for (int k = 0; k < 5; k++) wr(1'b1, 3 + k, 32'(11 * (k + 1)));
        wr(1'b1, 15, 32'hDEAD_BEEF);
        prog[0]  = enc_i(C_LDI, 0, 0, 16'd0);
        prog[1]  = enc_i(C_LDI, 3, 0, 16'd0);
        prog[2]  = enc_i(C_LDI, 4, 0, 16'd5);
        prog[3]  = enc_i(C_LD, 1, 0, 16'd3);
        prog[4]  = enc_r(C_ADD, 3, 3, 1);
        prog[5]  = enc_i(C_ADDI, 0, 0, 16'd1);
        prog[6]  = enc_i(C_BNE, 0, 4, 16'd12);
        prog[7]  = enc_i(C_ST, 3, 0, 16'd10);
        prog[8]  = enc_i(C_LD, 5, 4, 16'd10);
        prog[9]  = enc_i(C_LD, 6, 4, 16'hFFFE);
        prog[10] = enc_i(C_LDI, 7, 0, 16'h0055);
        prog[11] = enc_r(C_UNK, 7, 7, 7);
        prog[12] = enc_i(C_LD, 8, 0, 16'd10);
        prog[13] = enc_r(C_HALT, 0, 0, 0);
        run_prog(14, 5 * (3 + 5 * 4 + 7), "array");
        peek(3, v); check("R11 R5 array sum r3", v, 32'd165);
        peek(1, v); check("R5 last element r1", v, 32'd55);
        peek(5, v); check("R6 stored word read back", v, 32'd165);
        peek(6, v); check("R5 R3 negative offset load", v, 32'd11);
        peek(7, v); check("R10 R12 unknown opcode leaves rd", v, 32'h55);
        peek(8, v); check("R10 unknown opcode leaves data", v, 32'd165);
        peek(0, h0);
        peek(3, h3);
        repeat (20) @(negedge clk);
        check("R9 halted holds", 32'(halted), 32'd1);
        peek(0, v); check("R9 r0 holds after halt", v, h0);
        peek(3, v); check("R9 r3 holds after halt", v, h3);
        end_run();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule